// File: doc/BRIEF.md
# Stored Address Write Pointer

This block keeps a working address pointer into a user memory region so that a writer can store a stream of words without knowing where the free space starts. A single write whose word pointer equals the reserved redirect value 0x3FFF is taken as unaddressed: its target comes from the working pointer, not from the command. The pointer can advance by itself on each such write. When it reaches the last free location it either wraps back to a separately programmable initial address, which turns the region into a circular log, or it stops, which gives write-once behaviour. A block write stores a run of consecutive words starting at the pointer and leaves the pointer where it was.

Commands arrive as a one-cycle strobe carrying a type (single or block), a word pointer, a word count and a data word. Block data is fetched word by word through an index output. Each memory store goes out on a request/acknowledge port, and each command ends with a one-cycle done pulse that carries a success flag. An auto-lock mode reports every user word from the bottom of user memory up to the pointer as write-protected and refuses stores into that span.

The controller is a four-state machine. IDLE waits for a command and captures it (IDLE to DECIDE). DECIDE works out the target address, applies pointer-register writes, or rejects the command (DECIDE to WRITE when a store is needed, DECIDE to FINISH otherwise). WRITE holds the memory request until it is acknowledged, then steps to the next block word (WRITE to WRITE), or ends (WRITE to FINISH) on the last word or on running past the end of memory. FINISH raises done for one cycle and returns to IDLE.

Top module: `sap_ptr_ctrl`

## Requirements
- R1: After reset the working pointer and the initial address both read 0x006, the wrap flag is 0, and neither done nor mem_req is high.
- R2: A single write with word pointer 0x3FFF and auto-increment off stores its data at the current working pointer, reports success, and leaves the pointer unchanged.
- R3: A single write with word pointer 0x3FFF and auto-increment on stores its data at pointer plus one and leaves the pointer equal to the address just written; any other single write (other than to 0x0003) stores at the low ten bits of its word pointer and leaves the pointer alone.
- R4: With auto-increment on, wrap enabled, auto-lock off and the pointer equal to cfg_last_addr, the next unaddressed write stores at the initial address, loads the pointer with it and sets the wrap flag; a wrap_clr pulse clears the flag.
- R5: With auto-increment on, wrap disabled and the pointer equal to cfg_last_addr, an unaddressed write is refused: no memory store, done with ok=0, pointer unchanged.
- R6: A single write to word pointer 0x0003 makes no memory store; when its data bit 10 is 1 it loads the initial address from data bits 9:0 and leaves the working pointer untouched, otherwise it loads the working pointer from bits 9:0.
- R7: A block write stores words 0,1,2,... of its payload at consecutive addresses starting at the pointer (pointer plus one when auto-increment is on), never changes the pointer, and stops with ok=0 once the next address would pass cfg_last_addr.
- R8: A block write of more than 127 words stores every word but reports ok=0; a block write of zero words stores nothing and reports ok=0.
- R9: With auto-lock on, lock_hit is 1 exactly for query addresses from 0x004 up to the pointer inclusive, and a write whose target lies in that span is refused with no store.
- R10: mem_req stays high with a stable address until mem_ack, and done is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe, accepted while idle |
| cmd_block | input | 1 | 0 single write, 1 block write |
| cmd_ptr | input | 14 | Word pointer; 0x3FFF redirects, 0x0003 is the pointer register |
| cmd_count | input | 8 | Word count of a block write |
| cmd_data | input | 16 | Data of a single write |
| word_idx | output | 8 | Index of the block word wanted |
| word_data | input | 16 | Block payload word selected by word_idx |
| cfg_autoinc | input | 1 | Advance the pointer before an unaddressed store |
| cfg_wrap_en | input | 1 | Allow wrap to the initial address |
| cfg_autolock | input | 1 | Protect user words up to the pointer |
| cfg_last_addr | input | 10 | Last free user address for the current block size |
| mem_req | output | 1 | Memory store request |
| mem_addr | output | 10 | Store address |
| mem_wdata | output | 16 | Store data |
| mem_ack | input | 1 | One-cycle store acknowledge |
| done | output | 1 | One-cycle command completion |
| ok | output | 1 | Success flag, valid with done |
| wrap_clr | input | 1 | Clears the wrap flag |
| wrap_flag | output | 1 | Set when the pointer has wrapped |
| wsa | output | 10 | Working pointer |
| isa | output | 10 | Initial address |
| lock_qaddr | input | 10 | Address probed for auto-lock |
| lock_hit | output | 1 | Probed address is write-protected |

## Verification
The redirect path is driven through a sequence of single writes that alternates auto-increment off and on, interleaved with addressed writes and pointer-register loads, so that a store landing at the pointer, at pointer plus one or at the command's own address can be told apart by the recorded store address. The end of memory is approached twice, once with wrap off to show refusal and once with wrap on after moving the initial address, which separates a wrap to the initial address from a wrap to the reset value. Block writes are tried with and without auto-increment, running off the end, with zero words, and with 127 and 128 words, distinguishing the start offset, the abort and the size rule. Auto-lock is probed just below, inside and just above the protected span.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int PTR_W  = 14;
    localparam int CNT_W  = 8;

    localparam logic [PTR_W-1:0]  REDIRECT_PTR = 14'h3FFF;
    localparam logic [PTR_W-1:0]  PTR_REG_ADDR = 14'h0003;
    localparam logic [ADDR_W-1:0] RESET_PTR    = 10'h006;
    localparam logic [ADDR_W-1:0] USER_BASE    = 10'h004;
    localparam int                BLK_MAX      = 127;
    localparam int                INIT_SEL_BIT = 10;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DECIDE = 2'd1,
        S_WRITE  = 2'd2,
        S_FINISH = 2'd3
    } sap_state_e;
endpackage

// File: rtl/sap_ptr_regs.sv
module sap_ptr_regs
    import sap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] RST_VAL = RESET_PTR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_wsa,
    input  logic          ld_isa,
    input  logic [AW-1:0] ld_val,
    input  logic          wrap_set,
    input  logic          wrap_clr,
    output logic [AW-1:0] wsa,
    output logic [AW-1:0] isa,
    output logic          wrap_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsa       <= RST_VAL;
            isa       <= RST_VAL;
            wrap_flag <= 1'b0;
        end else begin
            if (ld_wsa) wsa <= ld_val;
            if (ld_isa) isa <= ld_val;
            if (wrap_set)      wrap_flag <= 1'b1;
            else if (wrap_clr) wrap_flag <= 1'b0;
        end
    end

    // R6
    isa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wsa |=> $stable(isa));
endmodule

// File: rtl/sap_lock_view.sv
module sap_lock_view
    import sap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] BASE = USER_BASE
) (
    input  logic          autolock,
    input  logic [AW-1:0] wsa,
    input  logic [AW-1:0] qaddr,
    output logic          hit
);
    always_comb begin
        hit = autolock && (qaddr >= BASE) && (qaddr <= wsa);
    end
endmodule

// File: rtl/sap_cmd_fsm.sv
module sap_cmd_fsm
    import sap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PTR_W,
    parameter int CW = CNT_W,
    parameter int MAXW = BLK_MAX,
    parameter logic [PW-1:0] REDIR = REDIRECT_PTR,
    parameter logic [PW-1:0] REGPTR = PTR_REG_ADDR,
    parameter logic [AW-1:0] BASE = USER_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_block,
    input  logic [PW-1:0] cmd_ptr,
    input  logic [CW-1:0] cmd_count,
    input  logic [DW-1:0] cmd_data,
    output logic [CW-1:0] word_idx,
    input  logic [DW-1:0] word_data,
    input  logic          cfg_autoinc,
    input  logic          cfg_wrap_en,
    input  logic          cfg_autolock,
    input  logic [AW-1:0] cfg_last_addr,
    input  logic [AW-1:0] wsa,
    input  logic [AW-1:0] isa,
    output logic          ld_wsa,
    output logic          ld_isa,
    output logic [AW-1:0] ld_val,
    output logic          wrap_set,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          done,
    output logic          ok,
    output logic          blk_busy
);
    localparam int AW1 = AW + 1;

    sap_state_e    state, state_nx;

    logic          blk_q;
    logic [PW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] idx_q;
    logic          move_q;
    logic          wrap_q;
    logic          ok_q;

    // decision terms evaluated in DECIDE
    logic          is_unaddr, is_regwr;
    logic          dec_store;
    logic          dec_ok;
    logic [AW-1:0] dec_addr;
    logic          dec_move;
    logic          dec_wrap;
    logic [AW1-1:0] wsa_inc;
    logic [AW1-1:0] blk_start;
    logic          last_word;
    logic          at_end;

    function automatic logic locked(input logic [AW-1:0] a, input logic [AW-1:0] p,
                                    input logic al);
        return al && (a >= BASE) && (a <= p);
    endfunction

    always_comb begin
        is_unaddr = !blk_q && (ptr_q == REDIR);
        is_regwr  = !blk_q && (ptr_q == REGPTR);
        wsa_inc   = {1'b0, wsa} + AW1'(1);
        blk_start = cfg_autoinc ? wsa_inc : {1'b0, wsa};

        dec_store = 1'b0;
        dec_ok    = 1'b0;
        dec_addr  = '0;
        dec_move  = 1'b0;
        dec_wrap  = 1'b0;

        if (is_regwr) begin
            dec_ok = 1'b1;
        end else if (blk_q) begin
            if ((cnt_q != '0) && (blk_start <= {1'b0, cfg_last_addr}) &&
                !locked(blk_start[AW-1:0], wsa, cfg_autolock)) begin
                dec_store = 1'b1;
                dec_addr  = blk_start[AW-1:0];
            end
        end else if (is_unaddr) begin
            if (!cfg_autoinc) begin
                if (!locked(wsa, wsa, cfg_autolock)) begin
                    dec_store = 1'b1;
                    dec_addr  = wsa;
                end
            end else if (wsa >= cfg_last_addr) begin
                if (cfg_wrap_en && !cfg_autolock) begin
                    dec_store = 1'b1;
                    dec_addr  = isa;
                    dec_move  = 1'b1;
                    dec_wrap  = 1'b1;
                end
            end else begin
                dec_store = 1'b1;
                dec_addr  = wsa_inc[AW-1:0];
                dec_move  = 1'b1;
            end
        end else begin
            if (!locked(ptr_q[AW-1:0], wsa, cfg_autolock)) begin
                dec_store = 1'b1;
                dec_addr  = ptr_q[AW-1:0];
            end
        end

        last_word = (idx_q + CW'(1)) >= cnt_q;
        at_end    = (addr_q >= cfg_last_addr);
    end

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cmd_valid) state_nx = S_DECIDE;
            S_DECIDE: state_nx = dec_store ? S_WRITE : S_FINISH;
            S_WRITE:  if (mem_ack && (!blk_q || last_word || at_end)) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            ptr_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
            idx_q  <= '0;
            move_q <= 1'b0;
            wrap_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        blk_q  <= cmd_block;
                        ptr_q  <= cmd_ptr;
                        cnt_q  <= cmd_count;
                        data_q <= cmd_data;
                    end
                end
                S_DECIDE: begin
                    addr_q <= dec_addr;
                    idx_q  <= '0;
                    move_q <= dec_move;
                    wrap_q <= dec_wrap;
                    ok_q   <= dec_ok;
                end
                S_WRITE: begin
                    if (mem_ack) begin
                        if (blk_q && !last_word && !at_end) begin
                            idx_q  <= idx_q + CW'(1);
                            addr_q <= addr_q + AW'(1);
                        end else if (blk_q) begin
                            ok_q <= last_word && (int'(cnt_q) <= MAXW);
                        end else begin
                            ok_q <= 1'b1;
                        end
                    end
                end
                S_FINISH: begin
                    move_q <= 1'b0;
                    wrap_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // output process
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = data_q;
        word_idx  = idx_q;
        done      = 1'b0;
        ok        = 1'b0;
        blk_busy  = 1'b0;
        ld_wsa    = 1'b0;
        ld_isa    = 1'b0;
        ld_val    = data_q[AW-1:0];
        wrap_set  = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_DECIDE: begin
                if (is_regwr) begin
                    ld_isa = data_q[INIT_SEL_BIT];
                    ld_wsa = !data_q[INIT_SEL_BIT];
                end
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                blk_busy  = blk_q;
                mem_wdata = blk_q ? word_data : data_q;
                if (mem_ack && move_q) begin
                    ld_wsa   = 1'b1;
                    ld_val   = addr_q;
                    wrap_set = wrap_q;
                end
            end
            S_FINISH: begin
                done = 1'b1;
                ok   = ok_q;
            end
            default: ;
        endcase
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/sap_ptr_ctrl.sv
module sap_ptr_ctrl
    import sap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PTR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_block,
    input  logic [PW-1:0] cmd_ptr,
    input  logic [CW-1:0] cmd_count,
    input  logic [DW-1:0] cmd_data,
    output logic [CW-1:0] word_idx,
    input  logic [DW-1:0] word_data,
    input  logic          cfg_autoinc,
    input  logic          cfg_wrap_en,
    input  logic          cfg_autolock,
    input  logic [AW-1:0] cfg_last_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          done,
    output logic          ok,
    input  logic          wrap_clr,
    output logic          wrap_flag,
    output logic [AW-1:0] wsa,
    output logic [AW-1:0] isa,
    input  logic [AW-1:0] lock_qaddr,
    output logic          lock_hit
);
    logic          ld_wsa, ld_isa, wrap_set, blk_busy;
    logic [AW-1:0] ld_val;

    sap_cmd_fsm #(.AW(AW), .DW(DW), .PW(PW), .CW(CW)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_block(cmd_block), .cmd_ptr(cmd_ptr),
        .cmd_count(cmd_count), .cmd_data(cmd_data),
        .word_idx(word_idx), .word_data(word_data),
        .cfg_autoinc(cfg_autoinc), .cfg_wrap_en(cfg_wrap_en),
        .cfg_autolock(cfg_autolock), .cfg_last_addr(cfg_last_addr),
        .wsa(wsa), .isa(isa),
        .ld_wsa(ld_wsa), .ld_isa(ld_isa), .ld_val(ld_val), .wrap_set(wrap_set),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .done(done), .ok(ok), .blk_busy(blk_busy)
    );

    sap_ptr_regs #(.AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_wsa(ld_wsa), .ld_isa(ld_isa), .ld_val(ld_val),
        .wrap_set(wrap_set), .wrap_clr(wrap_clr),
        .wsa(wsa), .isa(isa), .wrap_flag(wrap_flag)
    );

    sap_lock_view #(.AW(AW)) i_lock (
        .autolock(cfg_autolock), .wsa(wsa), .qaddr(lock_qaddr), .hit(lock_hit)
    );

    // R7
    blk_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_busy |=> $stable(wsa));

    // R9
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cfg_autolock) |-> !((mem_addr >= USER_BASE) && (mem_addr <= wsa)));

    // R4
    wrap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> $past(mem_req && mem_ack));
endmodule

// File: tb/test_sap_ptr_ctrl.sv
module test_sap_ptr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_block = 1'b0;
    logic [13:0] cmd_ptr = '0;
    logic [7:0]  cmd_count = '0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  word_idx;
    logic [15:0] word_data, blk_base = '0;
    logic        cfg_autoinc = 0, cfg_wrap_en = 0, cfg_autolock = 0;
    logic [9:0]  cfg_last_addr = 10'h00A;
    logic        mem_req, mem_ack = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        done, ok, wrap_clr = 1'b0, wrap_flag;
    logic [9:0]  wsa, isa, lock_qaddr = '0;
    logic        lock_hit;

    int errors = 0, checks = 0;
    int wr_cnt = 0;
    logic [9:0]  last_wa = '0;
    logic [15:0] last_wd = '0;
    logic [15:0] mem [1024];
    logic        got_ok;

    always #10 clk = ~clk;
    assign word_data = blk_base + {8'd0, word_idx};

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            mem[mem_addr] <= mem_wdata;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
        end
        mem_ack <= mem_req && !mem_ack;
    end

    sap_ptr_ctrl i_sap_ptr_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_block(cmd_block),
        .cmd_ptr(cmd_ptr), .cmd_count(cmd_count), .cmd_data(cmd_data),
        .word_idx(word_idx), .word_data(word_data),
        .cfg_autoinc(cfg_autoinc), .cfg_wrap_en(cfg_wrap_en),
        .cfg_autolock(cfg_autolock), .cfg_last_addr(cfg_last_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .done(done), .ok(ok), .wrap_clr(wrap_clr),
        .wrap_flag(wrap_flag), .wsa(wsa), .isa(isa),
        .lock_qaddr(lock_qaddr), .lock_hit(lock_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic blk, input logic [13:0] ptr,
                           input logic [7:0] cnt, input logic [15:0] dat);
        int n;
        @(negedge clk);
        cmd_block = blk; cmd_ptr = ptr; cmd_count = cnt; cmd_data = dat;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        got_ok = ok;
        if (!done) begin
            errors++;
            $display("FAIL R10 actual=timeout expected=done");
        end
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    typedef struct packed {
        logic        ai;
        logic        wr;
        logic [13:0] ptr;
        logic [15:0] data;
        logic        exp_ok;
        logic [9:0]  exp_wsa;
        logic        exp_wr;
        logic [9:0]  exp_addr;
    } vec_t;

    // R2 R3 R5 R6 R4 sequence, cfg_last_addr = 0x00A
    localparam vec_t TBL [0:8] = '{
        '{1'b0, 1'b0, 14'h3FFF, 16'hA001, 1'b1, 10'h006, 1'b1, 10'h006},
        '{1'b1, 1'b0, 14'h3FFF, 16'hA002, 1'b1, 10'h007, 1'b1, 10'h007},
        '{1'b1, 1'b0, 14'h3FFF, 16'hA003, 1'b1, 10'h008, 1'b1, 10'h008},
        '{1'b1, 1'b0, 14'h0020, 16'hA004, 1'b1, 10'h008, 1'b1, 10'h020},
        '{1'b0, 1'b0, 14'h0003, 16'h0009, 1'b1, 10'h009, 1'b0, 10'h000},
        '{1'b1, 1'b0, 14'h3FFF, 16'hA006, 1'b1, 10'h00A, 1'b1, 10'h00A},
        '{1'b1, 1'b0, 14'h3FFF, 16'hA007, 1'b0, 10'h00A, 1'b0, 10'h000},
        '{1'b0, 1'b0, 14'h0003, 16'h0405, 1'b1, 10'h00A, 1'b0, 10'h000},
        '{1'b1, 1'b1, 14'h3FFF, 16'hA009, 1'b1, 10'h005, 1'b1, 10'h005}
    };

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wsa", {22'd0, wsa}, 32'h006);
        chk("R1 isa", {22'd0, isa}, 32'h006);
        chk("R1 flags", {29'd0, wrap_flag, done, mem_req}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            cfg_autoinc = TBL[i].ai;
            cfg_wrap_en = TBL[i].wr;
            w0 = wr_cnt;
            run_cmd(1'b0, TBL[i].ptr, 8'd0, TBL[i].data);
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d ok", i), {31'd0, got_ok}, {31'd0, TBL[i].exp_ok});
            chk($sformatf("R2/R3/R4 vec%0d wsa", i), {22'd0, wsa}, {22'd0, TBL[i].exp_wsa});
            chk($sformatf("R5/R6 vec%0d stores", i), wr_cnt - w0, TBL[i].exp_wr ? 1 : 0);
            if (TBL[i].exp_wr) begin
                chk($sformatf("R2/R3 vec%0d addr", i), {22'd0, last_wa}, {22'd0, TBL[i].exp_addr});
                chk($sformatf("R2/R3 vec%0d data", i), {16'd0, last_wd}, {16'd0, TBL[i].data});
            end
            if (i == 7) chk("R6 isa loaded", {22'd0, isa}, 32'h005);
        end

        // R4 flag and clear
        chk("R4 wrap flag set", {31'd0, wrap_flag}, 32'd1);
        @(negedge clk) wrap_clr = 1'b1;
        @(negedge clk) wrap_clr = 1'b0;
        chk("R4 wrap flag cleared", {31'd0, wrap_flag}, 32'd0);

        // R9 auto-lock, wsa = 5
        cfg_wrap_en = 1'b0; cfg_autolock = 1'b1;
        lock_qaddr = 10'h003; #1 chk("R9 below base", {31'd0, lock_hit}, 32'd0);
        lock_qaddr = 10'h005; #1 chk("R9 at pointer", {31'd0, lock_hit}, 32'd1);
        lock_qaddr = 10'h004; #1 chk("R9 base", {31'd0, lock_hit}, 32'd1);
        lock_qaddr = 10'h006; #1 chk("R9 above", {31'd0, lock_hit}, 32'd0);
        w0 = wr_cnt;
        run_cmd(1'b0, 14'h0005, 8'd0, 16'hC005);
        chk("R9 locked write ok", {31'd0, got_ok}, 32'd0);
        chk("R9 locked no store", wr_cnt - w0, 0);
        run_cmd(1'b0, 14'h0006, 8'd0, 16'hC006);
        chk("R9 free write ok", {31'd0, got_ok}, 32'd1);
        chk("R9 free stored", {16'd0, mem[6]}, 32'hC006);
        cfg_autolock = 1'b0;

        // R7 block, auto-increment on
        cfg_autoinc = 1'b1; blk_base = 16'hB000;
        w0 = wr_cnt;
        run_cmd(1'b1, 14'h0000, 8'd3, 16'h0);
        chk("R7 block ok", {31'd0, got_ok}, 32'd1);
        chk("R7 block count", wr_cnt - w0, 3);
        chk("R7 first word", {16'd0, mem[6]}, 32'hB000);
        chk("R7 last word", {16'd0, mem[8]}, 32'hB002);
        chk("R7 pointer kept", {22'd0, wsa}, 32'h005);

        // R7 block runs past end: 5..A stored then abort
        cfg_autoinc = 1'b0; blk_base = 16'hD000;
        w0 = wr_cnt;
        run_cmd(1'b1, 14'h0000, 8'd10, 16'h0);
        chk("R7 overrun ok", {31'd0, got_ok}, 32'd0);
        chk("R7 overrun stores", wr_cnt - w0, 6);
        chk("R7 overrun start", {16'd0, mem[5]}, 32'hD000);
        chk("R7 overrun last", {22'd0, last_wa}, 32'h00A);

        // R8 sizes
        cfg_last_addr = 10'h3FF;
        w0 = wr_cnt;
        run_cmd(1'b1, 14'h0000, 8'd0, 16'h0);
        chk("R8 zero ok", {31'd0, got_ok}, 32'd0);
        chk("R8 zero stores", wr_cnt - w0, 0);
        blk_base = 16'hE000; w0 = wr_cnt;
        run_cmd(1'b1, 14'h0000, 8'd128, 16'h0);
        chk("R8 128 ok", {31'd0, got_ok}, 32'd0);
        chk("R8 128 stores", wr_cnt - w0, 128);
        chk("R8 128 last", {16'd0, mem[10'h084]}, 32'hE07F);
        w0 = wr_cnt;
        run_cmd(1'b1, 14'h0000, 8'd127, 16'h0);
        chk("R8 127 ok", {31'd0, got_ok}, 32'd1);
        chk("R8 127 stores", wr_cnt - w0, 127);
        chk("R7 pointer kept after blocks", {22'd0, wsa}, 32'h005);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule